// File: doc/BRIEF.md
# Framer Status Latch Bank

This block turns live status flags from an E1 framer into sticky bits that software can read. It keeps two 16-bit read values. The timer register records that a timer flag went from low to high. Those flags are the 10 ms flag, the 100 ms flag and the one-second flag. The alarm register records that an alarm flag went from low to high. Those flags are remote alarm, AIS, loss of signal and basic frame sync.

The timer bits are qualified by the basic-frame pulse. A timer bit is checked for a rising edge only in a cycle that carries that pulse. A timer bit is wiped by a read of its own register. It is also wiped by a read of the companion interrupt status register. The alarm bits are checked for a rising edge in every clock cycle. An alarm bit is wiped by a read of its register only if the alarm behind it has already gone away. This means software keeps seeing an active condition until the condition has ended.

Both read values are combinational views of the latches, so a read returns the state from before any clear. The clear takes effect on the clock edge that ends the read strobe.

Top module: `status_latch_bank`

## Requirements
- R1: A timer latch bit goes to 1 on the clock edge of a frame-pulse cycle if its live input is 1 in that cycle and was 0 at the previous frame pulse. Reset counts as a previous value of 0.
- R2: Timer latch bits never set in a cycle without a frame pulse. A live timer input that stays high across frame pulses does not set its bit again after a clear.
- R3: Timer register bit mapping: bit 2 = 10 ms flag, bit 1 = 100 ms flag, bit 0 = one-second flag. The input `timerLive` uses the same positions.
- R4: All timer latch bits clear on the edge that ends a read of the timer register (`rdStrobe`=1, `rdSel`=0) or an interrupt-register read (`intRdStrobe`=1). During the read cycle the old value is still visible.
- R5: An alarm latch bit goes to 1 on the clock edge after its live input rises, with no frame gating. Bit mapping: bit 3 = remote alarm, bit 2 = AIS, bit 1 = loss of signal, bit 0 = basic frame sync. The input `alarmLive` uses the same positions.
- R6: A read of the alarm register (`rdStrobe`=1, `rdSel`=1) clears only those alarm latch bits whose live input is 0 in the read cycle. Bits whose live input is still 1 stay set.
- R7: Timer register bits 15..3 and alarm register bits 15..4 always read 0.
- R8: If a set event and a clearing read fall in the same cycle, the bit ends up set.
- R9: After reset all latch bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameTick | input | 1 | Basic-frame pulse, one cycle wide |
| timerLive | input | 3 | Live timer flags {10 ms, 100 ms, 1 s} |
| alarmLive | input | 4 | Live alarm flags {remote, AIS, LOS, sync} |
| rdStrobe | input | 1 | Register read strobe |
| rdSel | input | 1 | Register select: 0 = timer register, 1 = alarm register |
| intRdStrobe | input | 1 | Read strobe of the companion interrupt status register |
| timerRegVal | output | 16 | Timer latch register read value |
| alarmRegVal | output | 16 | Alarm latch register read value |

## Verification
The bench walks every non-zero pattern of the timer flags and of the alarm flags.

For the timer flags it checks four things:
- A raised timer flag must not latch until a frame pulse arrives. A design that skipped the gating would show the bit one frame early.
- A flag held high across frame pulses must not set its bit again after a clear. A level-sensitive design would do so.
- A clear must follow a read of the timer register.
- A clear must also follow a read of the interrupt register. A design that ignored the interrupt read would leave the bit stuck.

For the alarm flags it checks two things:
- Reads made while the alarm is still high must leave the bit set. A design that cleared on every read would lose an alarm that is still active.
- After a partial drop of several active alarms, a read must clear only the dropped bits.

For same-cycle collisions of a rise and a clearing read, the bench checks that the set wins. A design that let the clear win would lose the event.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_TMR = 3;
  localparam int NUM_ALM = 4;

  // Strobes that the control decodes and hands to the datapath
  typedef struct packed {
    logic timerSample;  // frame pulse: sample the live timer flags
    logic timerClear;   // own-register read or interrupt-register read
    logic alarmRead;    // alarm register read
  } slb_strobes_t;
endpackage

// File: rtl/slb_ctrl.sv
module slb_ctrl
  import slb_pkg::*;
(
  input  logic         frameTick,
  input  logic         rdStrobe,
  input  logic         rdSel,
  input  logic         intRdStrobe,
  output slb_strobes_t st
);
  always_comb begin
    st.timerSample = frameTick;
    st.timerClear  = (rdStrobe && !rdSel) || intRdStrobe;
    st.alarmRead   = rdStrobe && rdSel;
  end
endmodule

// File: rtl/slb_datapath.sv
module slb_datapath
  import slb_pkg::*;
#(
  parameter int NT = NUM_TMR,
  parameter int NA = NUM_ALM
) (
  input  logic          clk,
  input  logic          rstN,
  input  slb_strobes_t  st,
  input  logic [NT-1:0] timerLive,
  input  logic [NA-1:0] alarmLive,
  output logic [NT-1:0] timerLatch,
  output logic [NA-1:0] alarmLatch
);
  logic [NT-1:0] timerPrev;
  logic [NA-1:0] alarmPrev;

  // Timer side: edge detection only at frame pulses
  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic setEv;
    assign setEv = st.timerSample && timerLive[i] && !timerPrev[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        timerPrev[i]  <= 1'b0;
        timerLatch[i] <= 1'b0;
      end else begin
        if (st.timerSample) timerPrev[i] <= timerLive[i];
        timerLatch[i] <= setEv || (timerLatch[i] && !st.timerClear);
      end
    end
  end

  // Alarm side: edge detection every cycle, clear only when the live flag is low
  for (genvar j = 0; j < NA; j++) begin : g_alm
    logic setEv;
    logic clrEv;
    assign setEv = alarmLive[j] && !alarmPrev[j];
    assign clrEv = st.alarmRead && !alarmLive[j];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        alarmPrev[j]  <= 1'b0;
        alarmLatch[j] <= 1'b0;
      end else begin
        alarmPrev[j]  <= alarmLive[j];
        alarmLatch[j] <= setEv || (alarmLatch[j] && !clrEv);
      end
    end

    AST_ALM_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
      (st.alarmRead && alarmLive[j] && alarmLatch[j]) |=> alarmLatch[j]);  // R6

    AST_ALM_RISE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
      $rose(alarmLive[j]) |=> alarmLatch[j]);  // R5
  end

  AST_TMR_FRAME_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !st.timerSample |=> ((timerLatch & ~$past(timerLatch)) == '0));  // R2

  AST_TMR_CLEAR_READ: assert property (@(posedge clk) disable iff (!rstN)
    (st.timerClear && !st.timerSample) |=> (timerLatch == '0));  // R4
endmodule

// File: rtl/status_latch_bank.sv
module status_latch_bank
  import slb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic [NUM_TMR-1:0] timerLive,
  input  logic [NUM_ALM-1:0] alarmLive,
  input  logic              rdStrobe,
  input  logic              rdSel,
  input  logic              intRdStrobe,
  output logic [REG_W-1:0]  timerRegVal,
  output logic [REG_W-1:0]  alarmRegVal
);
  localparam int TMR_PAD = REG_W - NUM_TMR;
  localparam int ALM_PAD = REG_W - NUM_ALM;

  slb_strobes_t      st;
  logic [NUM_TMR-1:0] timerLatch;
  logic [NUM_ALM-1:0] alarmLatch;

  slb_ctrl u_ctrl (
    .frameTick   (frameTick),
    .rdStrobe    (rdStrobe),
    .rdSel       (rdSel),
    .intRdStrobe (intRdStrobe),
    .st          (st)
  );

  slb_datapath #(.NT(NUM_TMR), .NA(NUM_ALM)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .timerLive  (timerLive),
    .alarmLive  (alarmLive),
    .timerLatch (timerLatch),
    .alarmLatch (alarmLatch)
  );

  assign timerRegVal = {{TMR_PAD{1'b0}}, timerLatch};
  assign alarmRegVal = {{ALM_PAD{1'b0}}, alarmLatch};
endmodule

// File: tb/tb_status_latch_bank.sv
module tb_status_latch_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameTick = 1'b0;
  logic [2:0]  timerLive = '0;
  logic [3:0]  alarmLive = '0;
  logic        rdStrobe = 1'b0;
  logic        rdSel = 1'b0;
  logic        intRdStrobe = 1'b0;
  logic [15:0] timerRegVal;
  logic [15:0] alarmRegVal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  status_latch_bank dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .timerLive(timerLive),
    .alarmLive(alarmLive), .rdStrobe(rdStrobe), .rdSel(rdSel),
    .intRdStrobe(intRdStrobe), .timerRegVal(timerRegVal), .alarmRegVal(alarmRegVal)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive strobes for one cycle, sample at the following falling edge
  task automatic cyc(input bit fr, input bit rd, input bit sel, input bit ird);
    frameTick = fr; rdStrobe = rd; rdSel = sel; intRdStrobe = ird;
    @(posedge clk);
    @(negedge clk);
    frameTick = 0; rdStrobe = 0; rdSel = 0; intRdStrobe = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 timer", timerRegVal, 16'h0);
    chk("R9 alarm", alarmRegVal, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Timer sweep over every non-zero flag pattern
    for (int p = 1; p < 8; p++) begin
      timerLive = '0; cyc(1, 0, 0, 0); cyc(0, 1, 0, 0);
      chk("R4 timer cleared", timerRegVal, 16'h0);
      timerLive = p[2:0]; cyc(0, 0, 0, 0);
      chk("R2 no set without frame", timerRegVal, 16'h0);
      cyc(1, 0, 0, 0);
      chk("R1 R3 R7 set at frame", timerRegVal, {13'h0, p[2:0]});
      rdStrobe = 1; rdSel = 0; #1;
      chk("R4 read shows pre-clear value", timerRegVal, {13'h0, p[2:0]});
      cyc(0, 1, 0, 0);
      chk("R4 own read clears", timerRegVal, 16'h0);
      cyc(1, 0, 0, 0);
      chk("R2 steady high no re-set", timerRegVal, 16'h0);
      timerLive = '0; cyc(1, 0, 0, 0);
      timerLive = p[2:0]; cyc(1, 0, 0, 0);
      chk("R1 re-set after low frame", timerRegVal, {13'h0, p[2:0]});
      cyc(0, 0, 0, 1);
      chk("R4 interrupt read clears", timerRegVal, 16'h0);
      cyc(0, 1, 1, 0);
      chk("R4 alarm read leaves timer", timerRegVal, 16'h0);
    end
    // R8 timer: set and own read in same cycle
    timerLive = '0; cyc(1, 0, 0, 0);
    timerLive = 3'b101; cyc(1, 1, 0, 0);
    chk("R8 timer set beats clear", timerRegVal, 16'h0005);
    cyc(0, 0, 0, 1);
    timerLive = '0;

    // Alarm sweep over every non-zero flag pattern
    for (int p = 1; p < 16; p++) begin
      alarmLive = '0; cyc(0, 1, 1, 0);
      chk("R6 alarm cleared when low", alarmRegVal, 16'h0);
      alarmLive = p[3:0]; cyc(0, 0, 0, 0);
      chk("R5 R7 alarm rise latches", alarmRegVal, {12'h0, p[3:0]});
      cyc(0, 1, 1, 0);
      chk("R6 read while active holds", alarmRegVal, {12'h0, p[3:0]});
      cyc(0, 1, 0, 0);
      chk("R6 timer read leaves alarm", alarmRegVal, {12'h0, p[3:0]});
      alarmLive = '0; cyc(0, 0, 0, 0);
      chk("R6 no clear without read", alarmRegVal, {12'h0, p[3:0]});
      cyc(0, 1, 1, 0);
      chk("R6 read after drop clears", alarmRegVal, 16'h0);
      alarmLive = p[3:0]; cyc(0, 0, 0, 0);
      alarmLive = p[3:0] & 4'b0101; cyc(0, 0, 0, 0);
      cyc(0, 1, 1, 0);
      chk("R6 partial drop clears dropped only", alarmRegVal, {12'h0, p[3:0] & 4'b0101});
    end
    // R8 alarm: rise and read in same cycle
    alarmLive = '0; cyc(0, 1, 1, 0);
    alarmLive = 4'b1010; cyc(0, 1, 1, 0);
    chk("R8 alarm set beats clear", alarmRegVal, 16'h000A);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule